// File: doc/BRIEF.md
# Field-Selected Hex/Decimal Nibble ALU

This block is the arithmetic and logic engine of a nibble-serial processor datapath. Registers are 16 nibbles wide. An operation does not touch the whole register. It acts on a field of consecutive nibbles named by a low and a high index. Nibbles outside that field leave the block exactly as they came in. Arithmetic ripples a carry or borrow from the low nibble up to the high nibble. Each nibble follows either plain hexadecimal rules or decimal digit rules, chosen per operation by a mode input. The carry out of the top field nibble becomes the carry flag.

The surrounding core presents two operand registers, an operation code, the field bounds, the mode and a 4-bit immediate, and pulses `opValid` for one cycle. On the next rising edge the block captures the new destination register (`resA`), the second register (`resB`, which changes only on an exchange), the carry flag, and a sticky flag. The sticky flag records that nonzero data fell off the bottom of a right shift. It stays set until the core pulses `stickyClr`. Instruction decode and the register file belong to the surrounding core.

Top module: `field_nibble_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released, `resA`, `resB`, `carryFlag`, `stickyFlag` and `opDone` are all 0.
- R2: Results and flags for an operation presented with `opValid` high appear at the first rising edge after it. `opDone` is high for exactly that one cycle and is low in every cycle that follows a cycle without `opValid`.
- R3: Nibble i occupies bits 4i+3..4i. The field is the set of nibbles i with `fieldLo` <= i <= `fieldHi`. Nibbles of `resA` outside the field equal those of `regA`. `resB` equals `regB` for every operation except exchange. If `fieldLo` > `fieldHi`, the field is empty: both results equal the inputs, and both flags keep their values except for `stickyClr`.
- R4: In hex mode (`decMode`=0), add (A+B), subtract (A−B), increment (A+1) and decrement (A−1) ripple from `fieldLo` to `fieldHi`. Each nibble gets its sum modulo 16. The carry is 1 whenever a nibble sum lies outside 0..15. The final carry goes to `carryFlag`.
- R5: In decimal mode (`decMode`=1), a nibble sum s of 10 or more gives s−10 with carry 1, and a nibble difference below 0 gives the difference plus 10 with borrow 1. Results wrap modulo 16.
- R6: Negate computes 0 − nibble − borrow across the field, using the current mode's rules. `carryFlag` becomes 1 exactly when some result nibble in the field is nonzero.
- R7: One's complement gives 15−d in hex mode. In decimal mode it gives 9−d for d ≤ 9 and 0 for d ≥ 10. `carryFlag` is unchanged.
- R8: AND, OR, clear, copy (field of A takes field of B) and exchange (fields of A and B swap) leave `carryFlag` unchanged.
- R9: Nibble shift left moves each field nibble up one place and puts 0 at `fieldLo`. Nibble shift right moves each field nibble down one place, puts 0 at `fieldHi`, and sets sticky if the nibble at `fieldLo` was nonzero. Rotate left moves the nibble at `fieldHi` to `fieldLo` and does not touch sticky. Rotate right moves the nibble at `fieldLo` to `fieldHi` and sets sticky if that nibble was nonzero. Shifts leave `carryFlag` unchanged.
- R10: The one-bit right shift sets sticky if bit 0 of the nibble at `fieldLo` was 1. Each field nibble shifts right by one bit and takes bit 0 of the nibble above it as its bit 3. The nibble at `fieldHi` takes 0 as its bit 3.
- R11: Add-immediate and subtract-immediate always use hex rules, whatever `decMode` says. They start the ripple with an initial carry of `immVal`+1, and the final carry goes to `carryFlag`.
- R12: Only an operation sets `stickyFlag`. `stickyClr` clears it in any cycle. When a setting operation and `stickyClr` arrive together, the flag ends up set. With neither, the flag holds.
- R13: `opCode` values are: 0 add, 1 sub, 2 inc, 3 dec, 4 negate, 5 one's complement, 6 AND, 7 OR, 8 clear, 9 copy, 10 exchange, 11 shift left, 12 shift right, 13 one-bit shift right, 14 rotate left, 15 rotate right, 16 add immediate, 17 subtract immediate. Any other code leaves `resA`, `resB` and `carryFlag` unchanged, though `opDone` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | One-cycle operation request |
| opCode | input | 5 | Operation select (R13) |
| fieldLo | input | 4 | Lowest field nibble index |
| fieldHi | input | 4 | Highest field nibble index |
| decMode | input | 1 | 1 selects decimal digit arithmetic |
| immVal | input | 4 | Immediate for add/subtract immediate |
| regA | input | 64 | First operand / destination source |
| regB | input | 64 | Second operand |
| stickyClr | input | 1 | Clears the sticky flag |
| resA | output | 64 | Registered destination result |
| resB | output | 64 | Registered second register (changes on exchange) |
| carryFlag | output | 1 | Registered carry / borrow / nonzero flag |
| stickyFlag | output | 1 | Registered sticky flag |
| opDone | output | 1 | Pulses the cycle results are valid |

## Verification
Every result, both flags and `opDone` are due one clock edge after the cycle in which `opValid` is high. A sticky clear is due one edge after `stickyClr`. The bench drives each request on a falling edge and drops it on the next falling edge. It compares the outputs at that second falling edge, half a period after the capturing edge and before any further request, so every comparison lands on the first cycle the result can exist. A reference model in the bench computes the expected registers and flags for every operation code, every pair of field bounds (including empty fields) and both modes. It carries the expected carry and sticky state from one operation to the next.

// File: rtl/fnalu_pkg.sv
package fnalu_pkg;

  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_SUB  = 5'd1;
  localparam logic [4:0] OP_INC  = 5'd2;
  localparam logic [4:0] OP_DEC  = 5'd3;
  localparam logic [4:0] OP_NEG  = 5'd4;
  localparam logic [4:0] OP_NOT  = 5'd5;
  localparam logic [4:0] OP_AND  = 5'd6;
  localparam logic [4:0] OP_OR   = 5'd7;
  localparam logic [4:0] OP_CLR  = 5'd8;
  localparam logic [4:0] OP_CPY  = 5'd9;
  localparam logic [4:0] OP_XCH  = 5'd10;
  localparam logic [4:0] OP_SHL  = 5'd11;
  localparam logic [4:0] OP_SHR  = 5'd12;
  localparam logic [4:0] OP_SRB  = 5'd13;
  localparam logic [4:0] OP_ROL  = 5'd14;
  localparam logic [4:0] OP_ROR  = 5'd15;
  localparam logic [4:0] OP_ADDI = 5'd16;
  localparam logic [4:0] OP_SUBI = 5'd17;

  typedef enum logic [3:0] {
    SEL_ARITH, SEL_ONESC, SEL_AND, SEL_OR, SEL_ZERO, SEL_COPYB,
    SEL_SHL, SEL_SHR, SEL_SRB, SEL_ROL, SEL_ROR, SEL_KEEP
  } resSel_e;

  typedef enum logic [1:0] {STK_NONE, STK_NIB, STK_BIT} stkSrc_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic    fire;        // load result registers
    resSel_e resSel;      // per-nibble result source
    logic    writeB;      // exchange: field of A goes to result B
    logic    subtract;    // ripple subtracts instead of adds
    logic    zeroX;       // first arithmetic operand forced to 0
    logic    yFromA;      // second arithmetic operand taken from A
    logic    yZero;       // second arithmetic operand forced to 0
    logic [4:0] cInit;    // initial carry into nibble fieldLo
    logic    forceHex;    // ignore decimal mode
    logic    carryWr;     // operation updates the carry flag
    logic    carryFromNz; // carry flag = any nonzero result nibble
    stkSrc_e stkSrc;      // sticky source
  } aluStrobe_t;

endpackage

// File: rtl/fnalu_ctrl.sv
module fnalu_ctrl
  import fnalu_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            opValid,
  input  logic [4:0]      opCode,
  input  logic [IDXW-1:0] fieldLo,
  input  logic [IDXW-1:0] fieldHi,
  input  logic [3:0]      immVal,
  input  logic            stickyClr,
  input  logic            carryOut,
  input  logic            nzField,
  input  logic            lowNibNz,
  input  logic            lowBit0,
  output aluStrobe_t      strobe,
  output logic            carryFlag,
  output logic            stickyFlag,
  output logic            opDone
);

  logic fieldEmpty;
  logic stickyHit;
  logic carryLoad;

  assign fieldEmpty = (fieldLo > fieldHi);

  always_comb begin
    strobe = '{fire: 1'b1, resSel: SEL_ARITH, writeB: 1'b0, subtract: 1'b0,
               zeroX: 1'b0, yFromA: 1'b0, yZero: 1'b0, cInit: 5'd0,
               forceHex: 1'b0, carryWr: 1'b0, carryFromNz: 1'b0,
               stkSrc: STK_NONE};
    unique case (opCode)
      OP_ADD:  strobe.carryWr = 1'b1;
      OP_SUB:  begin strobe.carryWr = 1'b1; strobe.subtract = 1'b1; end
      OP_INC:  begin strobe.carryWr = 1'b1; strobe.yZero = 1'b1; strobe.cInit = 5'd1; end
      OP_DEC:  begin
        strobe.carryWr = 1'b1; strobe.yZero = 1'b1; strobe.cInit = 5'd1;
        strobe.subtract = 1'b1;
      end
      OP_NEG:  begin
        strobe.carryWr = 1'b1; strobe.carryFromNz = 1'b1; strobe.subtract = 1'b1;
        strobe.zeroX = 1'b1; strobe.yFromA = 1'b1;
      end
      OP_NOT:  strobe.resSel = SEL_ONESC;
      OP_AND:  strobe.resSel = SEL_AND;
      OP_OR:   strobe.resSel = SEL_OR;
      OP_CLR:  strobe.resSel = SEL_ZERO;
      OP_CPY:  strobe.resSel = SEL_COPYB;
      OP_XCH:  begin strobe.resSel = SEL_COPYB; strobe.writeB = 1'b1; end
      OP_SHL:  strobe.resSel = SEL_SHL;
      OP_SHR:  begin strobe.resSel = SEL_SHR; strobe.stkSrc = STK_NIB; end
      OP_SRB:  begin strobe.resSel = SEL_SRB; strobe.stkSrc = STK_BIT; end
      OP_ROL:  strobe.resSel = SEL_ROL;
      OP_ROR:  begin strobe.resSel = SEL_ROR; strobe.stkSrc = STK_NIB; end
      OP_ADDI: begin
        strobe.carryWr = 1'b1; strobe.yZero = 1'b1; strobe.forceHex = 1'b1;
        strobe.cInit = {1'b0, immVal} + 5'd1;
      end
      OP_SUBI: begin
        strobe.carryWr = 1'b1; strobe.yZero = 1'b1; strobe.forceHex = 1'b1;
        strobe.subtract = 1'b1; strobe.cInit = {1'b0, immVal} + 5'd1;
      end
      default: begin strobe.fire = 1'b0; strobe.resSel = SEL_KEEP; end
    endcase
  end

  always_comb begin
    unique case (strobe.stkSrc)
      STK_NIB: stickyHit = lowNibNz;
      STK_BIT: stickyHit = lowBit0;
      default: stickyHit = 1'b0;
    endcase
    stickyHit = stickyHit && opValid && !fieldEmpty;
  end

  assign carryLoad = opValid && strobe.fire && strobe.carryWr && !fieldEmpty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carryFlag  <= 1'b0;
      stickyFlag <= 1'b0;
      opDone     <= 1'b0;
    end else begin
      opDone <= opValid;
      if (carryLoad) carryFlag <= strobe.carryFromNz ? nzField : carryOut;
      if (stickyHit)      stickyFlag <= 1'b1;
      else if (stickyClr) stickyFlag <= 1'b0;
    end
  end

  // R2: completion pulse follows the request by one edge
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    opValid |=> opDone);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> !opDone);
  // R8: operations that do not own the carry leave it alone
  a_r8_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !strobe.carryWr) |=> $stable(carryFlag));
  // R12: sticky holds unless cleared
  a_r12_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stickyFlag && !stickyClr) |=> stickyFlag);
  a_r12_sticky_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stickyFlag) |-> $past(opValid));

endmodule

// File: rtl/fnalu_datapath.sv
module fnalu_datapath
  import fnalu_pkg::*;
#(
  parameter int NIB  = 16,
  parameter int IDXW = 4,
  parameter int W    = 4 * NIB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            opValid,
  input  aluStrobe_t      strobe,
  input  logic            decMode,
  input  logic [IDXW-1:0] fieldLo,
  input  logic [IDXW-1:0] fieldHi,
  input  logic [W-1:0]    regA,
  input  logic [W-1:0]    regB,
  output logic            carryOut,
  output logic            nzField,
  output logic            lowNibNz,
  output logic            lowBit0,
  output logic [W-1:0]    resA,
  output logic [W-1:0]    resB
);

  logic [NIB-1:0] inField;
  logic [W-1:0]   fieldBits;
  logic [W-1:0]   opX, opY, arithRes;
  logic [W-1:0]   upSrc, dnSrc;
  logic [W-1:0]   nextA, nextB;
  logic [3:0]     lowNib, highNib;
  logic           useHex;

  always_comb begin
    for (int n = 0; n < NIB; n++) begin
      inField[n] = (n >= int'(fieldLo)) && (n <= int'(fieldHi));
      fieldBits[4*n +: 4] = {4{inField[n]}};
    end
  end

  assign lowNib   = regA[4*fieldLo +: 4];
  assign highNib  = regA[4*fieldHi +: 4];
  assign lowNibNz = (lowNib != 4'h0);
  assign lowBit0  = lowNib[0];

  assign opX    = strobe.zeroX ? '0 : regA;
  assign opY    = strobe.yZero ? '0 : (strobe.yFromA ? regA : regB);
  assign useHex = strobe.forceHex || !decMode;

  // ripple chain from fieldLo to fieldHi
  always_comb begin
    int c;
    int s;
    c = int'(strobe.cInit);
    s = 0;
    arithRes = opX;
    for (int n = 0; n < NIB; n++) begin
      if (inField[n]) begin
        if (strobe.subtract) s = int'(opX[4*n +: 4]) - int'(opY[4*n +: 4]) - c;
        else                 s = int'(opX[4*n +: 4]) + int'(opY[4*n +: 4]) + c;
        if (useHex) begin
          arithRes[4*n +: 4] = 4'(s);
          c = (s < 0 || s > 15) ? 1 : 0;
        end else if (strobe.subtract) begin
          if (s < 0) begin arithRes[4*n +: 4] = 4'(s + 10); c = 1; end
          else       begin arithRes[4*n +: 4] = 4'(s);      c = 0; end
        end else begin
          if (s >= 10) begin arithRes[4*n +: 4] = 4'(s - 10); c = 1; end
          else         begin arithRes[4*n +: 4] = 4'(s);      c = 0; end
        end
      end
    end
    carryOut = (c != 0);
  end

  assign nzField = |(arithRes & fieldBits);

  // neighbour nibbles: upSrc nibble i = A nibble i-1, dnSrc nibble i = A nibble i+1
  assign upSrc = {regA[W-5:0], 4'h0};
  assign dnSrc = {4'h0, regA[W-1:4]};

  for (genvar i = 0; i < NIB; i++) begin : g_nib
    logic [3:0] aN, bN, selN;
    logic       atLo, atHi;
    assign aN   = regA[4*i +: 4];
    assign bN   = regB[4*i +: 4];
    assign atLo = (fieldLo == IDXW'(i));
    assign atHi = (fieldHi == IDXW'(i));

    always_comb begin
      unique case (strobe.resSel)
        SEL_ARITH: selN = arithRes[4*i +: 4];
        SEL_ONESC: selN = useHex ? ~aN : ((aN <= 4'd9) ? 4'd9 - aN : 4'd0);
        SEL_AND:   selN = aN & bN;
        SEL_OR:    selN = aN | bN;
        SEL_ZERO:  selN = 4'h0;
        SEL_COPYB: selN = bN;
        SEL_SHL:   selN = atLo ? 4'h0 : upSrc[4*i +: 4];
        SEL_SHR:   selN = atHi ? 4'h0 : dnSrc[4*i +: 4];
        SEL_SRB:   selN = {atHi ? 1'b0 : dnSrc[4*i], aN[3:1]};
        SEL_ROL:   selN = atLo ? highNib : upSrc[4*i +: 4];
        SEL_ROR:   selN = atHi ? lowNib : dnSrc[4*i +: 4];
        default:   selN = aN;
      endcase
    end

    assign nextA[4*i +: 4] = inField[i] ? selN : aN;
    assign nextB[4*i +: 4] = (inField[i] && strobe.writeB) ? aN : bN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resA <= '0;
      resB <= '0;
    end else if (opValid && strobe.fire) begin
      resA <= nextA;
      resB <= nextB;
    end
  end

  // R3: nibbles outside the field pass through
  a_r3_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && strobe.fire) |=> (((resA ^ $past(regA)) & ~$past(fieldBits)) == '0));
  // R3: second register only changes on exchange
  a_r3_b_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && strobe.fire && !strobe.writeB) |=> (resB == $past(regB)));
  // R13: undefined codes leave results held
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !strobe.fire) |=> ($stable(resA) && $stable(resB)));

endmodule

// File: rtl/field_nibble_alu.sv
module field_nibble_alu
  import fnalu_pkg::*;
#(
  parameter int NIB  = 16,
  localparam int IDXW = $clog2(NIB),
  localparam int W    = 4 * NIB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            opValid,
  input  logic [4:0]      opCode,
  input  logic [IDXW-1:0] fieldLo,
  input  logic [IDXW-1:0] fieldHi,
  input  logic            decMode,
  input  logic [3:0]      immVal,
  input  logic [W-1:0]    regA,
  input  logic [W-1:0]    regB,
  input  logic            stickyClr,
  output logic [W-1:0]    resA,
  output logic [W-1:0]    resB,
  output logic            carryFlag,
  output logic            stickyFlag,
  output logic            opDone
);

  aluStrobe_t strobe;
  logic carryOut, nzField, lowNibNz, lowBit0;

  fnalu_ctrl #(.IDXW(IDXW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .fieldLo(fieldLo), .fieldHi(fieldHi), .immVal(immVal),
    .stickyClr(stickyClr), .carryOut(carryOut), .nzField(nzField),
    .lowNibNz(lowNibNz), .lowBit0(lowBit0), .strobe(strobe),
    .carryFlag(carryFlag), .stickyFlag(stickyFlag), .opDone(opDone)
  );

  fnalu_datapath #(.NIB(NIB), .IDXW(IDXW), .W(W)) dp_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .strobe(strobe),
    .decMode(decMode), .fieldLo(fieldLo), .fieldHi(fieldHi),
    .regA(regA), .regB(regB), .carryOut(carryOut), .nzField(nzField),
    .lowNibNz(lowNibNz), .lowBit0(lowBit0), .resA(resA), .resB(resB)
  );

  // R1: everything leaves reset at zero
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (resA == '0 && resB == '0 && !carryFlag && !stickyFlag && !opDone));

endmodule

// File: tb/field_nibble_alu_tb.sv
`timescale 1ns/1ps
module field_nibble_alu_tb_top;
  localparam int NIB = 16;
  localparam int W   = 4 * NIB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [3:0] fieldLo = '0, fieldHi = '0;
  logic decMode = 1'b0;
  logic [3:0] immVal = '0;
  logic [W-1:0] regA = '0, regB = '0;
  logic stickyClr = 1'b0;
  logic [W-1:0] resA, resB;
  logic carryFlag, stickyFlag, opDone;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // expected state carried across operations
  logic [W-1:0] expA = '0, expB = '0;
  bit expCarry = 1'b0, expSticky = 1'b0;

  always #4 clk = ~clk;

  field_nibble_alu #(.NIB(NIB)) dut_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .fieldLo(fieldLo), .fieldHi(fieldHi), .decMode(decMode), .immVal(immVal),
    .regA(regA), .regB(regB), .stickyClr(stickyClr), .resA(resA), .resB(resB),
    .carryFlag(carryFlag), .stickyFlag(stickyFlag), .opDone(opDone)
  );

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input int op, input bit dm, input bit empty);
    if (empty) return "R3";
    if (op <= 3) return dm ? "R5" : "R4";
    if (op == 4) return "R6";
    if (op == 5) return "R7";
    if (op <= 10) return "R8";
    if (op == 13) return "R10";
    if (op <= 15) return "R9";
    if (op <= 17) return "R11";
    return "R13";
  endfunction

  // reference model built from the requirements
  task automatic model(input int op, input int lo, input int hi, input bit dm,
                       input int im, input logic [W-1:0] a, input logic [W-1:0] b);
    int A[NIB], B[NIB], R[NIB], Q[NIB];
    bit hit = 0;
    for (int n = 0; n < NIB; n++) begin
      A[n] = int'(a[4*n +: 4]); B[n] = int'(b[4*n +: 4]);
      R[n] = A[n]; Q[n] = B[n];
    end
    if (op > 17) return;
    if (lo <= hi) begin
      if (op <= 4 || op >= 16) begin
        int c, s, x, y;
        bit sub, hex, nz;
        sub = (op == 1 || op == 3 || op == 4 || op == 17);
        hex = !dm || op >= 16;
        c = (op == 2 || op == 3) ? 1 : (op >= 16 ? im + 1 : 0);
        nz = 0;
        for (int n = lo; n <= hi; n++) begin
          x = (op == 4) ? 0 : A[n];
          y = (op == 0 || op == 1) ? B[n] : (op == 4 ? A[n] : 0);
          s = sub ? x - y - c : x + y + c;
          if (hex) begin R[n] = s & 15; c = (s < 0 || s > 15) ? 1 : 0; end
          else if (sub) begin c = (s < 0) ? 1 : 0; R[n] = (s < 0 ? s + 10 : s) & 15; end
          else begin c = (s >= 10) ? 1 : 0; R[n] = (s >= 10 ? s - 10 : s) & 15; end
          if (R[n] != 0) nz = 1;
        end
        expCarry = (op == 4) ? nz : (c != 0);
      end else begin
        for (int n = lo; n <= hi; n++) begin
          case (op)
            5:  R[n] = dm ? (A[n] <= 9 ? 9 - A[n] : 0) : 15 - A[n];
            6:  R[n] = A[n] & B[n];
            7:  R[n] = A[n] | B[n];
            8:  R[n] = 0;
            9:  R[n] = B[n];
            10: begin R[n] = B[n]; Q[n] = A[n]; end
            11: R[n] = (n == lo) ? 0 : A[n-1];
            12: R[n] = (n == hi) ? 0 : A[n+1];
            13: R[n] = (A[n] >> 1) | ((n < hi) ? ((A[n+1] & 1) << 3) : 0);
            14: R[n] = (n == lo) ? A[hi] : A[n-1];
            default: R[n] = (n == hi) ? A[lo] : A[n+1];
          endcase
        end
        if (op == 12 || op == 15) hit = (A[lo] != 0);
        if (op == 13) hit = (A[lo] & 1) != 0;
      end
    end
    for (int n = 0; n < NIB; n++) begin
      expA[4*n +: 4] = 4'(R[n]); expB[4*n +: 4] = 4'(Q[n]);
    end
    if (hit) expSticky = 1'b1;
  endtask

  task automatic runOp(input int op, input int lo, input int hi, input bit dm,
                       input int im, input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit clr);
    string t;
    bit oldSticky;
    oldSticky = expSticky;
    if (clr) expSticky = 1'b0;
    model(op, lo, hi, dm, im, a, b);
    t = tagOf(op, dm, lo > hi);
    @(negedge clk);
    opValid = 1'b1; opCode = 5'(op); fieldLo = 4'(lo); fieldHi = 4'(hi);
    decMode = dm; immVal = 4'(im); regA = a; regB = b; stickyClr = clr;
    @(negedge clk);
    opValid = 1'b0; stickyClr = 1'b0;
    chk(t, "resA", resA, expA);
    chk((op == 10 || op > 17) ? t : "R3", "resB", resB, expB);
    chk(t, "carry", W'(carryFlag), W'(expCarry));
    chk((op == 12 || op == 13 || op == 15) && (lo <= hi) && !oldSticky ? t : "R12",
        "sticky", W'(stickyFlag), W'(expSticky));
    chk("R2", "done", W'(opDone), W'(1));
  endtask

  function automatic logic [W-1:0] randReg(input bit digits);
    logic [W-1:0] v;
    for (int k = 0; k < NIB; k++) v[4*k +: 4] = digits ? 4'($urandom % 10) : 4'($urandom % 16);
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "resA in reset", resA, '0);
    chk("R1", "flags in reset", W'({carryFlag, stickyFlag, opDone}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "resB after reset", resB, '0);
    chk("R2", "done idle", W'(opDone), '0);

    // R5 directed: 0999 + 1 over nibbles 0..3 -> 1000, no carry out
    runOp(0, 0, 3, 1, 0, 64'h0999, 64'h0001, 0);
    chk("R5", "decimal chain", resA, 64'h1000);
    // R5 directed: 9999 + 1 -> 0000 with carry
    runOp(0, 0, 3, 1, 0, 64'h9999, 64'h0001, 0);
    chk("R5", "decimal carry out", W'(carryFlag), W'(1));
    // R7 directed: decimal complement of C is 0, of 3 is 6
    runOp(5, 0, 1, 1, 0, 64'h3C, 64'h0, 0);
    chk("R7", "decimal complement", resA, 64'h60);
    // R11 directed: immediate ignores decimal mode: 9 + (5+1) = F
    runOp(16, 0, 0, 1, 5, 64'h9, 64'h0, 0);
    chk("R11", "hex immediate", resA, 64'hF);

    // R12 directed: set by rotate right, hold, clear, set-and-clear together
    runOp(15, 0, 1, 0, 0, 64'h05, 64'h0, 0);
    repeat (2) @(negedge clk);
    chk("R12", "sticky holds", W'(stickyFlag), W'(1));
    stickyClr = 1'b1; @(negedge clk); stickyClr = 1'b0;
    chk("R12", "sticky cleared", W'(stickyFlag), W'(0));
    chk("R2", "no done without op", W'(opDone), W'(0));
    expSticky = 1'b0;
    runOp(14, 0, 1, 0, 0, 64'h05, 64'h0, 0);
    chk("R9", "rotate left keeps sticky clear", W'(stickyFlag), W'(0));
    runOp(13, 0, 1, 0, 0, 64'h01, 64'h0, 1);
    chk("R12", "set wins over clear", W'(stickyFlag), W'(1));

    // sweep: every code, every field, both modes
    for (int op = 0; op < 20; op++)
      for (int lo = 0; lo < NIB; lo++)
        for (int hi = 0; hi < NIB; hi++)
          for (int dm = 0; dm < 2; dm++) begin
            bit digits = (dm == 1) && ((lo + hi) % 2 == 0);
            runOp(op, lo, hi, dm[0], int'($urandom % 16), randReg(digits),
                  randReg(digits), ($urandom % 4) == 0);
          end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule